// File: doc/BRIEF.md
# Bank-Switching Page Controller

This block sits beside a plug-in ROM on a host bus that fetches 10-bit instruction words from a 16-bit word address space. It watches every fetch. When the fetch address falls inside the module's own 4K-word page, the block asserts a page hit. When the word fetched there is one of four reserved bank-enable opcodes, the block records the matching bank. The host treats those opcodes as no-operations and does nothing else with them.

The recorded bank index is placed above the 12 page-offset bits to form the ROM address. As a result, only the chosen 4K image is visible in the page. The page the module answers at comes from fixed port-derived bits after reset. A relocation load replaces those bits with a programmed page number. The number of implemented banks is a parameter. A two-bank build ignores the opcodes for banks 3 and 4.

Top module: `bsw_page_ctrl`

## Requirements
- R1: After reset the bank index is 0 (bank 1), the page in use is `port_page`, and `page_hit` is low while `fetch_valid` is low.
- R2: A bank-enable opcode fetched with a page hit selects a bank index. Opcode 0x100 selects index 0 (bank 1), 0x180 selects index 1, 0x140 selects index 2 and 0x1C0 selects index 3 (bank 4).
- R3: A bank-enable opcode fetched from an address outside the module's page leaves the bank index unchanged.
- R4: A new bank index appears on `cur_bank` and `rom_addr` one clock after the enable fetch. The enable fetch itself is still addressed with the previous bank.
- R5: `rom_addr` equals `{cur_bank, fetch_addr[11:0]}` in the same cycle as the fetch.
- R6: `page_hit` is high exactly when `fetch_valid` is high and `fetch_addr[15:12]` equals the page in use.
- R7: A one-cycle `page_load` makes `page_value` the page in use from the next cycle on. After that, `port_page` has no effect until the next reset.
- R8: Words that are not one of the four opcodes, and any word presented with `fetch_valid` low, leave the bank index unchanged.
- R9: With NUM_BANKS = 2, the opcodes 0x140 and 0x1C0 leave the bank index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_page | input | PAGE_W (4) | Fixed page number derived from the port the module is plugged into |
| page_load | input | 1 | Loads `page_value` as the relocated page |
| page_value | input | PAGE_W (4) | Relocated page number |
| fetch_valid | input | 1 | A fetch is present on this cycle |
| fetch_addr | input | ADDR_W (16) | Word address of the fetch |
| fetch_word | input | WORD_W (10) | Instruction word fetched |
| page_hit | output | 1 | The fetch falls inside the module's page |
| cur_bank | output | BANK_W (2) | Bank index currently visible |
| rom_addr | output | BANK_W+12 (14) | Address into the multi-bank ROM |

## Verification
`page_hit` and `rom_addr` are combinational and are due in the same cycle as the fetch. The bank index changes one clock after an enable fetch, and a relocation takes effect one clock after `page_load`. The driver changes inputs on the falling edge and pushes, for that same cycle, the values it expects from a model that updates its bank and page only after the push. The monitor pops and compares one time unit later, still before the next rising edge. A late or early bank update therefore shows up on the very next fetch.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  localparam int OPC_W = 10;

  typedef struct packed {
    logic       is_enable;
    logic [1:0] idx;
  } bank_cmd_t;

  // Enable opcodes share 01_xx00_0000; bank index is {w[6], w[7]}
  function automatic bank_cmd_t decode_opc(input logic [OPC_W-1:0] w);
    bank_cmd_t r;
    r.is_enable = (w[9:8] == 2'b01) && (w[5:0] == 6'd0);
    r.idx       = {w[6], w[7]};
    return r;
  endfunction

  function automatic logic page_equal(input logic [3:0] a, input logic [3:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/bsw_opc_decode.sv
module bsw_opc_decode
  import bsw_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0] word,
  input  logic              qualify,
  output logic              cmd_hit,
  output logic [1:0]        cmd_idx
);
  bank_cmd_t dec;
  logic      upper_clear;

  generate
    if (WORD_W > OPC_W) begin : g_wide
      assign upper_clear = (word[WORD_W-1:OPC_W] == '0);
    end else begin : g_exact
      assign upper_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    dec     = decode_opc(word[OPC_W-1:0]);
    cmd_hit = qualify && upper_clear && dec.is_enable;
    cmd_idx = dec.idx;
  end
endmodule

// File: rtl/bsw_page_sel.sv
module bsw_page_sel #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] port_page,
  input  logic              page_load,
  input  logic [PAGE_W-1:0] page_value,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [PAGE_W-1:0] eff_page,
  output logic              page_hit
);
  logic [PAGE_W-1:0] reloc_q;
  logic              reloc_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloc_q    <= '0;
      reloc_en_q <= 1'b0;
    end else if (page_load) begin
      reloc_q    <= page_value;
      reloc_en_q <= 1'b1;
    end
  end

  assign eff_page = reloc_en_q ? reloc_q : port_page;
  assign page_hit = fetch_valid && (fetch_addr[ADDR_W-1 -: PAGE_W] == eff_page);
endmodule

// File: rtl/bsw_bank_reg.sv
module bsw_bank_reg #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  logic [1:0]        cmd_idx,
  output logic              bank_take,
  output logic [BANK_W-1:0] bank_q
);
  generate
    if (NUM_BANKS >= 4) begin : g_full
      assign bank_take = cmd_hit;
    end else begin : g_part
      assign bank_take = cmd_hit && (int'(cmd_idx) < NUM_BANKS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         bank_q <= '0;
    else if (bank_take) bank_q <= cmd_idx[BANK_W-1:0];
  end
endmodule

// File: rtl/bsw_page_ctrl.sv
module bsw_page_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int WORD_W    = 10,
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = (NUM_BANKS > 2) ? 2 : 1,
  localparam int OFFS_W   = ADDR_W - PAGE_W,
  localparam int ROM_AW   = BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] port_page,
  input  logic              page_load,
  input  logic [PAGE_W-1:0] page_value,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [WORD_W-1:0] fetch_word,
  output logic              page_hit,
  output logic [BANK_W-1:0] cur_bank,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [PAGE_W-1:0] eff_page;
  logic              cmd_hit;
  logic [1:0]        cmd_idx;
  logic              bank_take;

  bsw_page_sel #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .port_page(port_page), .page_load(page_load),
    .page_value(page_value), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .eff_page(eff_page), .page_hit(page_hit)
  );

  bsw_opc_decode #(.WORD_W(WORD_W)) u_dec (
    .word(fetch_word), .qualify(page_hit), .cmd_hit(cmd_hit), .cmd_idx(cmd_idx)
  );

  bsw_bank_reg #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .cmd_idx(cmd_idx),
    .bank_take(bank_take), .bank_q(cur_bank)
  );

  assign rom_addr = {cur_bank, fetch_addr[OFFS_W-1:0]};
endmodule

// File: rtl/bsw_page_ctrl_chk.sv
module bsw_page_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_load,
  input logic [PAGE_W-1:0] page_value,
  input logic              fetch_valid,
  input logic              page_hit,
  input logic [PAGE_W-1:0] eff_page,
  input logic              cmd_hit,
  input logic [1:0]        cmd_idx,
  input logic              bank_take,
  input logic [BANK_W-1:0] cur_bank
);
  p_reset_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cur_bank == '0);

  p_enable_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_take |=> cur_bank == $past(cmd_idx[BANK_W-1:0]));

  p_own_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |-> page_hit);

  p_hit_needs_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_hit |-> fetch_valid);

  p_relocate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_load |=> eff_page == $past(page_value));

  p_hold_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_take |=> $stable(cur_bank));

  p_bank_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_take |-> int'(cmd_idx) < NUM_BANKS);
endmodule

bind bsw_page_ctrl bsw_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .page_load(page_load), .page_value(page_value),
  .fetch_valid(fetch_valid), .page_hit(page_hit), .eff_page(eff_page),
  .cmd_hit(cmd_hit), .cmd_idx(cmd_idx), .bank_take(bank_take), .cur_bank(cur_bank)
);

// File: tb/bsw_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module bsw_page_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  port_page = 4'h3;
  logic        page_load = 1'b0;
  logic [3:0]  page_value = 4'h0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = 16'h0;
  logic [9:0]  fetch_word = 10'h0;

  logic        hit4, hit2;
  logic [1:0]  bank4;
  logic [0:0]  bank2;
  logic [13:0] rom4;
  logic [12:0] rom2;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bsw_page_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .port_page(port_page), .page_load(page_load),
    .page_value(page_value), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_word(fetch_word), .page_hit(hit4), .cur_bank(bank4), .rom_addr(rom4)
  );

  bsw_page_ctrl #(.NUM_BANKS(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .port_page(port_page), .page_load(page_load),
    .page_value(page_value), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_word(fetch_word), .page_hit(hit2), .cur_bank(bank2), .rom_addr(rom2)
  );

  typedef struct {
    string tag;
    int    hit;
    int    bank4;
    int    bank2;
    int    rom4;
    int    rom2;
  } exp_t;

  exp_t sb[$];

  int  m_bank4 = 0;
  int  m_bank2 = 0;
  int  m_page  = 3;
  bit  m_reloc = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int opc_bank(input int w);
    case (w)
      'h100: return 0;
      'h180: return 1;
      'h140: return 2;
      'h1C0: return 3;
      default: return -1;
    endcase
  endfunction

  // driver: one bus cycle, expectation pushed for the same cycle
  task automatic fetch(input string tag, input bit v, input int addr, input int word);
    exp_t e;
    int   b;
    int   pg;
    @(negedge clk);
    fetch_valid = v;
    fetch_addr  = addr[15:0];
    fetch_word  = word[9:0];
    pg = m_reloc ? m_page : int'(port_page);
    e.tag   = tag;
    e.hit   = (v && ((addr >> 12) & 'hF) == pg) ? 1 : 0;
    e.bank4 = m_bank4;
    e.bank2 = m_bank2;
    e.rom4  = (m_bank4 << 12) | (addr & 'hFFF);
    e.rom2  = (m_bank2 << 12) | (addr & 'hFFF);
    sb.push_back(e);
    b = opc_bank(word);
    if (e.hit == 1 && b >= 0) begin
      m_bank4 = b;
      if (b < 2) m_bank2 = b;
    end
  endtask

  task automatic relocate(input int pg);
    @(negedge clk);
    fetch_valid = 1'b0;
    page_load   = 1'b1;
    page_value  = pg[3:0];
    @(negedge clk);
    page_load = 1'b0;
    m_page  = pg;
    m_reloc = 1'b1;
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "hit4", int'(hit4), e.hit);
      check(e.tag, "hit2", int'(hit2), e.hit);
      check(e.tag, "bank4", int'(bank4), e.bank4);
      check(e.tag, "bank2", int'(bank2), e.bank2);
      check(e.tag, "rom4", int'(rom4), e.rom4);
      check(e.tag, "rom2", int'(rom2), e.rom2);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "bank4", int'(bank4), 0);
    check("R1", "bank2", int'(bank2), 0);
    check("R1", "hit idle", int'(hit4), 0);

    fetch("R1_home_page", 1, 'h3123, 'h2A5);
    fetch("R5_offset",    1, 'h3ABC, 'h000);
    fetch("R6_other_page", 1, 'h4123, 'h000);
    fetch("R4_enable_uses_old", 1, 'h3FC0, 'h180);
    fetch("R2_bank2", 1, 'h3FC9, 'h000);
    fetch("R9_bank3", 1, 'h3010, 'h140);
    fetch("R2_bank3_seen", 1, 'h3FCB, 'h000);
    fetch("R9_bank4", 1, 'h3020, 'h1C0);
    fetch("R2_bank4_seen", 1, 'h3FCD, 'h000);
    fetch("R3_foreign_enable", 1, 'h5000, 'h100);
    fetch("R3_after_foreign", 1, 'h3001, 'h000);
    fetch("R8_near_opcode", 1, 'h3002, 'h181);
    fetch("R8_near_opcode2", 1, 'h3003, 'h300);
    fetch("R8_invalid_fetch", 0, 'h3004, 'h100);
    fetch("R8_after_invalid", 1, 'h3005, 'h000);
    fetch("R2_bank1", 1, 'h3FC7, 'h100);
    fetch("R2_bank1_seen", 1, 'h3006, 'h000);
    fetch("R2_b2_again", 1, 'h3007, 'h180);
    fetch("R9_b2_kept", 1, 'h3008, 'h140);

    relocate(5);
    fetch("R7_new_page", 1, 'h5123, 'h000);
    fetch("R7_old_page", 1, 'h3123, 'h000);
    fetch("R7_enable_new", 1, 'h5FFF, 'h100);
    @(negedge clk);
    port_page = 4'h9;
    fetch("R7_port_ignored", 1, 'h9000, 'h1C0);
    fetch("R7_still_reloc", 1, 'h5001, 'h000);
    fetch("R6_idle", 0, 'h5001, 'h000);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule